// File: doc/BRIEF.md
# Misaligned Load/Store Split Sequencer

This block sits behind the address generator of a load/store unit whose data cache uses 64-byte lines and whose memory is mapped in 4 KB pages. An access of 1, 2, 4 or 8 bytes arrives with its virtual address and the physical frame that the first translation already produced. The block works out whether the bytes fit in one line. If they do not, it works out whether the next line is still in the same page. It then drives one or two line requests to the cache port. A page-crossing access gets its own translation for the next virtual page before any cache traffic starts. This way a translation fault ends the access before a single byte has been read or written.

Load bytes are picked out of the line responses, with the lower-addressed fragment taken from the first line and the rest from the second. They come back little-endian and right-aligned, and the unused upper bytes are zero. For stores, each line request carries its own byte-enable set and its own write-data lanes. The two sets together enable exactly the bytes of the access. The two fragments have no ordering promise between them, so the block does nothing extra for coherence.

Top module: `mas_split_seq`

## Requirements
- R1: After a synchronous reset the block is idle: busy, tlb_req_valid, cache_req_valid and done_valid are all low.
- R2: A request is taken on a clock edge where in_valid is high and busy is low. From that edge busy stays high up to and including the done_valid cycle, and it is low in the cycle after. While busy is high, in_valid and the other request inputs have no effect.
- R3: in_size encodes the length as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Let off be in_vaddr[5:0]. When off + length <= 64, the block issues exactly one cache request, at line address {in_ppn, in_vaddr[11:6]}, and no TLB request. done_valid rises in the cycle after the last response that the access consumes.
- R4: When off + length > 64 and in_vaddr[11:6] is not 63, the block issues a second cache request at {in_ppn, in_vaddr[11:6] + 1} after the first one, and no TLB request.
- R5: When off + length > 64 and in_vaddr[11:6] is 63, the block first issues a TLB request for virtual page in_vaddr[31:12] + 1. Only after that response does it make the first cache request at {in_ppn, in_vaddr[11:6]}. The second cache request goes to {tlb_resp_ppn, 6'b0}.
- R6: If that TLB response has tlb_resp_fault high, the block makes no cache request for the access. It raises done_valid with done_fault high, and done_fault_va holds the virtual address of the start of the next line, ((in_vaddr >> 6) + 1) << 6.
- R7: For a load, done_rdata byte i (bits 8i+7:8i) holds the memory byte at virtual address in_vaddr + i for i below the length. The remaining bytes are zero. For a store, done_rdata is zero.
- R8: For a store, the first request enables line bytes off up to min(off + length, 64) - 1. The second request enables bytes 0 up to off + length - 65. The write data byte in each enabled lane is in_wdata byte (lane position - off) for the first request, and (lane position + 64 - off) for the second.
- R9: cache_req_valid and tlb_req_valid each stay high, with their address and data fields stable, until the cycle their response is seen. The two are never high together. done_valid lasts exactly one cycle.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New access present |
| in_vaddr | input | VA_W | Virtual byte address of the access |
| in_size | input | 2 | Length code (R3) |
| in_store | input | 1 | 1 = store, 0 = load |
| in_wdata | input | 64 | Store data, right-aligned little-endian |
| in_ppn | input | PA_W-12 | Physical frame of in_vaddr |
| busy | output | 1 | Access in flight, new requests held off |
| tlb_req_valid | output | 1 | Translation request for the next page |
| tlb_req_vpn | output | VA_W-12 | Virtual page to translate |
| tlb_resp_valid | input | 1 | Translation response |
| tlb_resp_ppn | input | PA_W-12 | Translated frame |
| tlb_resp_fault | input | 1 | Translation miss or fault |
| cache_req_valid | output | 1 | Line request |
| cache_req_line | output | PA_W-6 | Physical line address |
| cache_req_store | output | 1 | Line request writes |
| cache_req_be | output | 64 | Byte enables for the line |
| cache_req_wdata | output | 512 | Write data lanes for the line |
| cache_resp_valid | input | 1 | Line response |
| cache_resp_rdata | input | 512 | Line read data |
| done_valid | output | 1 | Access complete, one-cycle pulse |
| done_fault | output | 1 | Access aborted by a second-page fault |
| done_fault_va | output | VA_W | Virtual address of the faulting fragment |
| done_rdata | output | 64 | Load result |

## Verification
On every cycle, assertions check the handshake rules: requests are held until they are answered, only one port is asked at a time, busy stays up until done, done lasts one cycle, a faulting translation leads straight to done with no cache request, and an unsplit store enables exactly its own length. The choice of line addresses, the order of translation against the cache fragments, the byte lanes of both store fragments and the merged load bytes can only be shown by the scoreboard scenarios. Those scenarios cover the exact line-end boundaries (offset 63 with one byte, offset 56 with eight), in-page and page-crossing splits, faults on loads and stores, and request inputs held active while the block is busy.

// File: rtl/mas_pkg.sv
package mas_pkg;

    localparam int LINE_BYTES = 64;
    localparam int LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_OFF_W = $clog2(PAGE_BYTES);
    localparam int IDX_W      = PAGE_OFF_W - LINE_OFF_W;
    localparam int ACC_BYTES  = 8;
    localparam int ACC_IDX_W  = $clog2(ACC_BYTES);
    localparam int ACC_W      = ACC_BYTES * 8;
    localparam int CNT_W      = LINE_OFF_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_TLB2,
        ST_REQ_HI,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                  straddle;
        logic                  page_cross;
        logic [LINE_OFF_W-1:0] off;
        logic [CNT_W-1:0]      nbytes;
    } split_info_t;

    function automatic logic [CNT_W-1:0] size_to_bytes(acc_size_e sz);
        return CNT_W'(1) << sz;
    endfunction

    function automatic split_info_t classify(logic [PAGE_OFF_W-1:0] pofs, acc_size_e sz);
        split_info_t      r;
        logic [CNT_W-1:0] endp;
        r.off        = pofs[LINE_OFF_W-1:0];
        r.nbytes     = size_to_bytes(sz);
        endp         = {1'b0, r.off} + r.nbytes;
        r.straddle   = endp > CNT_W'(LINE_BYTES);
        r.page_cross = r.straddle && (&pofs[PAGE_OFF_W-1:LINE_OFF_W]);
        return r;
    endfunction

    function automatic logic crosses_page(logic [PAGE_OFF_W-1:0] pofs, acc_size_e sz);
        split_info_t r;
        r = classify(pofs, sz);
        return r.page_cross;
    endfunction

    function automatic logic [ACC_W-1:0] size_data_mask(acc_size_e sz);
        logic [ACC_W-1:0] m;
        for (int i = 0; i < ACC_BYTES; i++)
            m[i*8 +: 8] = (i < int'(size_to_bytes(sz))) ? 8'hFF : 8'h00;
        return m;
    endfunction

endpackage

// File: rtl/mas_split_detect.sv
module mas_split_detect
    import mas_pkg::*;
(
    input  logic [PAGE_OFF_W-1:0] page_ofs,
    input  acc_size_e             size,
    output split_info_t           info,
    output logic [LINE_BYTES-1:0] lo_be,
    output logic [LINE_BYTES-1:0] hi_be
);
    localparam int BM_W  = 2 * ACC_BYTES;
    localparam int WIN_W = 2 * LINE_BYTES;

    logic [BM_W-1:0]  run;
    logic [WIN_W-1:0] win;

    always_comb begin
        info  = classify(page_ofs, size);
        run   = (BM_W'(1) << info.nbytes) - BM_W'(1);
        win   = {{(WIN_W-ACC_BYTES){1'b0}}, run[ACC_BYTES-1:0]} << info.off;
        lo_be = win[LINE_BYTES-1:0];
        hi_be = win[WIN_W-1:LINE_BYTES];
    end

endmodule

// File: rtl/mas_store_lanes.sv
module mas_store_lanes
    import mas_pkg::*;
(
    input  logic [ACC_W-1:0]      wdata,
    input  logic [LINE_OFF_W-1:0] off,
    output logic [LINE_W-1:0]     lo_wd,
    output logic [LINE_W-1:0]     hi_wd
);
    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        logic [CNT_W-1:0] rel_lo;
        logic [CNT_W-1:0] rel_hi;
        assign rel_lo = CNT_W'(k) - {1'b0, off};
        assign rel_hi = CNT_W'(k + LINE_BYTES) - {1'b0, off};
        assign lo_wd[k*8 +: 8] = (rel_lo < CNT_W'(ACC_BYTES))
                               ? wdata[rel_lo[ACC_IDX_W-1:0]*8 +: 8] : 8'h00;
        assign hi_wd[k*8 +: 8] = (rel_hi < CNT_W'(ACC_BYTES))
                               ? wdata[rel_hi[ACC_IDX_W-1:0]*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/mas_load_align.sv
module mas_load_align
    import mas_pkg::*;
(
    input  logic [LINE_W-1:0]     line,
    input  logic [LINE_OFF_W-1:0] off,
    input  logic                  sel_hi,
    output logic [ACC_W-1:0]      part
);
    for (genvar j = 0; j < ACC_BYTES; j++) begin : g_byte
        logic [CNT_W-1:0] pos;
        assign pos = {1'b0, off} + CNT_W'(j);
        assign part[j*8 +: 8] = (pos[LINE_OFF_W] == sel_hi)
                              ? line[pos[LINE_OFF_W-1:0]*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/mas_split_seq.sv
module mas_split_seq
    import mas_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [VA_W-1:0]            in_vaddr,
    input  logic [1:0]                 in_size,
    input  logic                       in_store,
    input  logic [ACC_W-1:0]           in_wdata,
    input  logic [PA_W-PAGE_OFF_W-1:0] in_ppn,
    output logic                       busy,
    output logic                       tlb_req_valid,
    output logic [VA_W-PAGE_OFF_W-1:0] tlb_req_vpn,
    input  logic                       tlb_resp_valid,
    input  logic [PA_W-PAGE_OFF_W-1:0] tlb_resp_ppn,
    input  logic                       tlb_resp_fault,
    output logic                       cache_req_valid,
    output logic [PA_W-LINE_OFF_W-1:0] cache_req_line,
    output logic                       cache_req_store,
    output logic [LINE_BYTES-1:0]      cache_req_be,
    output logic [LINE_W-1:0]          cache_req_wdata,
    input  logic                       cache_resp_valid,
    input  logic [LINE_W-1:0]          cache_resp_rdata,
    output logic                       done_valid,
    output logic                       done_fault,
    output logic [VA_W-1:0]            done_fault_va,
    output logic [ACC_W-1:0]           done_rdata
);
    localparam int VPN_W = VA_W - PAGE_OFF_W;
    localparam int PPN_W = PA_W - PAGE_OFF_W;

    seq_state_e        st_q;
    logic [VA_W-1:0]   va_q;
    acc_size_e         size_q;
    logic              store_q;
    logic [ACC_W-1:0]  wdata_q;
    logic [ACC_W-1:0]  res_q;
    logic [PPN_W-1:0]  ppn_lo_q;
    logic [PPN_W-1:0]  ppn_hi_q;
    logic              fault_q;

    logic              in_pcross;
    split_info_t       info_q;
    logic [LINE_BYTES-1:0] lo_be, hi_be;
    logic [LINE_W-1:0] lo_wd, hi_wd;
    logic [ACC_W-1:0]  part;
    logic [ACC_W-1:0]  mask;
    logic              on_hi;
    logic [IDX_W-1:0]  idx_q;
    logic [VPN_W-1:0]  vpn_q;

    assign idx_q     = va_q[PAGE_OFF_W-1:LINE_OFF_W];
    assign vpn_q     = va_q[VA_W-1:PAGE_OFF_W];
    assign on_hi     = (st_q == ST_REQ_HI);
    assign mask      = size_data_mask(size_q);
    assign in_pcross = crosses_page(in_vaddr[PAGE_OFF_W-1:0], acc_size_e'(in_size));

    mas_split_detect u_detect (
        .page_ofs (va_q[PAGE_OFF_W-1:0]),
        .size     (size_q),
        .info     (info_q),
        .lo_be    (lo_be),
        .hi_be    (hi_be)
    );

    mas_store_lanes u_lanes (
        .wdata (wdata_q),
        .off   (info_q.off),
        .lo_wd (lo_wd),
        .hi_wd (hi_wd)
    );

    mas_load_align u_align (
        .line   (cache_resp_rdata),
        .off    (info_q.off),
        .sel_hi (on_hi),
        .part   (part)
    );

    always_comb begin
        busy            = (st_q != ST_IDLE);
        tlb_req_valid   = (st_q == ST_TLB2);
        tlb_req_vpn     = vpn_q + VPN_W'(1);
        cache_req_valid = (st_q == ST_REQ_LO) || on_hi;
        if (!on_hi)
            cache_req_line = {ppn_lo_q, idx_q};
        else if (info_q.page_cross)
            cache_req_line = {ppn_hi_q, IDX_W'(0)};
        else
            cache_req_line = {ppn_lo_q, idx_q + IDX_W'(1)};
        cache_req_store = store_q;
        cache_req_be    = on_hi ? hi_be : lo_be;
        cache_req_wdata = on_hi ? hi_wd : lo_wd;
        done_valid      = (st_q == ST_DONE);
        done_fault      = done_valid && fault_q;
        done_fault_va   = {va_q[VA_W-1:LINE_OFF_W] + (VA_W-LINE_OFF_W)'(1), LINE_OFF_W'(0)};
        done_rdata      = res_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            va_q     <= '0;
            size_q   <= SZ_1B;
            store_q  <= 1'b0;
            wdata_q  <= '0;
            res_q    <= '0;
            ppn_lo_q <= '0;
            ppn_hi_q <= '0;
            fault_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        va_q     <= in_vaddr;
                        size_q   <= acc_size_e'(in_size);
                        store_q  <= in_store;
                        wdata_q  <= in_store ? in_wdata : '0;
                        ppn_lo_q <= in_ppn;
                        res_q    <= '0;
                        fault_q  <= 1'b0;
                        st_q     <= in_pcross ? ST_TLB2 : ST_REQ_LO;
                    end
                end
                ST_TLB2: begin
                    if (tlb_resp_valid) begin
                        if (tlb_resp_fault) begin
                            fault_q <= 1'b1;
                            st_q    <= ST_DONE;
                        end else begin
                            ppn_hi_q <= tlb_resp_ppn;
                            st_q     <= ST_REQ_LO;
                        end
                    end
                end
                ST_REQ_LO: begin
                    if (cache_resp_valid) begin
                        if (!store_q) res_q <= part & mask;
                        st_q <= info_q.straddle ? ST_REQ_HI : ST_DONE;
                    end
                end
                ST_REQ_HI: begin
                    if (cache_resp_valid) begin
                        if (!store_q) res_q <= res_q | (part & mask);
                        st_q <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9: only one downstream port is asked at a time
    a_r9_one_port: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tlb_req_valid, cache_req_valid}));

    // R9: an unanswered line request keeps its address
    a_r9_cache_hold: assert property (@(posedge clk) disable iff (rst)
        cache_req_valid && !cache_resp_valid |=> cache_req_valid && $stable(cache_req_line) && $stable(cache_req_be));

    // R9: an unanswered translation request keeps its page
    a_r9_tlb_hold: assert property (@(posedge clk) disable iff (rst)
        tlb_req_valid && !tlb_resp_valid |=> tlb_req_valid && $stable(tlb_req_vpn));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R2: busy holds until completion and drops right after it
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (rst)
        busy && !done_valid |=> busy);
    a_r2_free_after_done: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !busy);

    // R6: a faulting second-page translation ends the access with no cache traffic
    a_r6_fault_aborts: assert property (@(posedge clk) disable iff (rst)
        tlb_req_valid && tlb_resp_valid && tlb_resp_fault |=> done_valid && done_fault && !cache_req_valid);

    // R8: a store that fits in one line enables exactly its own length
    a_r8_single_be: assert property (@(posedge clk) disable iff (rst)
        cache_req_valid && cache_req_store && !info_q.straddle |-> $countones(cache_req_be) == int'(info_q.nbytes));

endmodule

// File: tb/mas_split_seq_tb.sv
module mas_split_seq_tb;
    import mas_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int VPN_W = VA_W - PAGE_OFF_W;
    localparam int PPN_W = PA_W - PAGE_OFF_W;
    localparam int LN_W  = PA_W - LINE_OFF_W;
    localparam int WDOG  = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [VA_W-1:0]  in_vaddr = '0;
    logic [1:0]       in_size = '0;
    logic             in_store = 1'b0;
    logic [ACC_W-1:0] in_wdata = '0;
    logic [PPN_W-1:0] in_ppn = '0;
    logic             busy;
    logic             tlb_req_valid;
    logic [VPN_W-1:0] tlb_req_vpn;
    logic             tlb_resp_valid = 1'b0;
    logic [PPN_W-1:0] tlb_resp_ppn = '0;
    logic             tlb_resp_fault = 1'b0;
    logic             cache_req_valid;
    logic [LN_W-1:0]  cache_req_line;
    logic             cache_req_store;
    logic [LINE_BYTES-1:0] cache_req_be;
    logic [LINE_W-1:0] cache_req_wdata;
    logic             cache_resp_valid = 1'b0;
    logic [LINE_W-1:0] cache_resp_rdata = '0;
    logic             done_valid;
    logic             done_fault;
    logic [VA_W-1:0]  done_fault_va;
    logic [ACC_W-1:0] done_rdata;

    typedef struct {
        logic [LN_W-1:0]       line;
        logic                  st;
        logic [LINE_BYTES-1:0] be;
        logic [LINE_W-1:0]     wd;
        string                 rq;
    } cache_exp_t;

    typedef struct {
        logic             fault;
        logic [VA_W-1:0]  fva;
        logic [ACC_W-1:0] rd;
    } done_exp_t;

    cache_exp_t       cq[$];
    done_exp_t        dq[$];
    logic [VPN_W-1:0] tq[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat_sel = 0;
    int last_resp_cyc = 0;
    logic [PPN_W-1:0] tlb_ppn_v = '0;
    logic             tlb_fault_v = 1'b0;

    mas_split_seq #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
        .clk, .rst, .in_valid, .in_vaddr, .in_size, .in_store, .in_wdata, .in_ppn,
        .busy, .tlb_req_valid, .tlb_req_vpn, .tlb_resp_valid, .tlb_resp_ppn, .tlb_resp_fault,
        .cache_req_valid, .cache_req_line, .cache_req_store, .cache_req_be, .cache_req_wdata,
        .cache_resp_valid, .cache_resp_rdata,
        .done_valid, .done_fault, .done_fault_va, .done_rdata
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(logic [LN_W-1:0] line, int k);
        logic [31:0] t;
        t = 32'(line) * 32'd29 + 32'(k) * 32'd7 + 32'd3;
        return t[7:0];
    endfunction

    function automatic logic [LINE_W-1:0] be_to_bits(logic [LINE_BYTES-1:0] be);
        logic [LINE_W-1:0] m;
        for (int k = 0; k < LINE_BYTES; k++) m[k*8 +: 8] = be[k] ? 8'hFF : 8'h00;
        return m;
    endfunction

    // cache responder and request monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cache_req_valid) begin
                logic [LN_W-1:0] line_now;
                line_now = cache_req_line;
                if (cq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected cache request", 64'(cache_req_line), 64'h0);
                end else begin
                    cache_exp_t e;
                    e = cq.pop_front();
                    chk(cache_req_line == e.line, e.rq, "line address", 64'(cache_req_line), 64'(e.line));
                    chk(cache_req_store == e.st, e.rq, "store flag", 64'(cache_req_store), 64'(e.st));
                    if (e.st) begin
                        chk(cache_req_be == e.be, "R8", "byte enables", cache_req_be, e.be);
                        chk(((cache_req_wdata ^ e.wd) & be_to_bits(e.be)) == '0, "R8", "write lanes",
                            64'(cache_req_wdata >> (8*$clog2(LINE_BYTES))), 64'(e.wd >> (8*$clog2(LINE_BYTES))));
                    end
                end
                for (int w = 0; w < lat_sel; w++) begin
                    @(negedge clk);
                    chk(cache_req_valid && cache_req_line == line_now, "R9", "request held",
                        64'(cache_req_line), 64'(line_now));
                end
                for (int k = 0; k < LINE_BYTES; k++)
                    cache_resp_rdata[k*8 +: 8] = mem_byte(line_now, k);
                cache_resp_valid = 1'b1;
                last_resp_cyc = cyc;
                @(negedge clk);
                cache_resp_valid = 1'b0;
            end
        end
    end

    // translation responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tlb_req_valid) begin
                if (tq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected TLB request", 64'(tlb_req_vpn), 64'h0);
                end else begin
                    logic [VPN_W-1:0] ev;
                    ev = tq.pop_front();
                    chk(tlb_req_vpn == ev, "R5", "next page number", 64'(tlb_req_vpn), 64'(ev));
                end
                chk(!cache_req_valid, "R5", "translation before cache", 64'(cache_req_valid), 64'h0);
                repeat (lat_sel) @(negedge clk);
                tlb_resp_valid = 1'b1;
                tlb_resp_ppn   = tlb_ppn_v;
                tlb_resp_fault = tlb_fault_v;
                last_resp_cyc  = cyc;
                @(negedge clk);
                tlb_resp_valid = 1'b0;
                tlb_resp_fault = 1'b0;
            end
        end
    end

    // completion monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_valid) begin
                chk(cyc == last_resp_cyc + 1, "R3", "done one cycle after last response",
                    64'(cyc), 64'(last_resp_cyc + 1));
                if (dq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected completion", 64'h1, 64'h0);
                end else begin
                    done_exp_t d;
                    d = dq.pop_front();
                    chk(done_fault == d.fault, "R6", "fault flag", 64'(done_fault), 64'(d.fault));
                    if (d.fault)
                        chk(done_fault_va == d.fva, "R6", "fault address", 64'(done_fault_va), 64'(d.fva));
                    else
                        chk(done_rdata == d.rd, "R7 R9", "load result", done_rdata, d.rd);
                end
            end
        end
    end

    task automatic issue(input logic [VA_W-1:0] va, input logic [1:0] sz, input logic st,
                         input logic [ACC_W-1:0] wd, input logic [PPN_W-1:0] ppn,
                         input logic [PPN_W-1:0] tppn, input logic tfault, input bit hold);
        int n, off;
        logic [IDX_W-1:0] idx;
        logic straddle, pc;
        logic [LN_W-1:0] lo_line, hi_line;
        cache_exp_t elo, ehi;
        done_exp_t  d;
        n   = 1 << sz;
        off = int'(va[LINE_OFF_W-1:0]);
        idx = va[PAGE_OFF_W-1:LINE_OFF_W];
        straddle = (off + n) > LINE_BYTES;
        pc  = straddle && (&idx);
        lo_line = {ppn, idx};
        hi_line = pc ? {tppn, IDX_W'(0)} : {ppn, idx + IDX_W'(1)};
        tlb_ppn_v   = tppn;
        tlb_fault_v = tfault;
        lat_sel     = (lat_sel + 1) % 3;
        if (pc) tq.push_back(va[VA_W-1:PAGE_OFF_W] + VPN_W'(1));
        d.fault = 1'b0; d.fva = '0; d.rd = '0;
        if (pc && tfault) begin
            d.fault = 1'b1;
            d.fva   = ((va >> LINE_OFF_W) + 1) << LINE_OFF_W;
        end else begin
            elo.line = lo_line; elo.st = st; elo.be = '0; elo.wd = '0; elo.rq = "R3";
            ehi.line = hi_line; ehi.st = st; ehi.be = '0; ehi.wd = '0; ehi.rq = pc ? "R5" : "R4";
            for (int i = 0; i < n; i++) begin
                int pos;
                pos = off + i;
                if (pos < LINE_BYTES) begin
                    elo.be[pos] = 1'b1;
                    elo.wd[pos*8 +: 8] = wd[i*8 +: 8];
                    if (!st) d.rd[i*8 +: 8] = mem_byte(lo_line, pos);
                end else begin
                    ehi.be[pos-LINE_BYTES] = 1'b1;
                    ehi.wd[(pos-LINE_BYTES)*8 +: 8] = wd[i*8 +: 8];
                    if (!st) d.rd[i*8 +: 8] = mem_byte(hi_line, pos - LINE_BYTES);
                end
            end
            cq.push_back(elo);
            if (straddle) cq.push_back(ehi);
        end
        dq.push_back(d);
        @(negedge clk);
        while (busy) @(negedge clk);
        in_vaddr = va; in_size = sz; in_store = st; in_wdata = wd; in_ppn = ppn;
        in_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            // R2: a different request held active while busy must be ignored
            in_vaddr = va ^ 32'h0000_0FC7; in_size = 2'd3; in_store = ~st;
            in_wdata = ~wd; in_ppn = ~ppn;
        end else begin
            in_valid = 1'b0;
        end
        while (!done_valid) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(!busy, "R2", "idle after done", 64'(busy), 64'h0);
        chk(cq.size() == 0, "R3", "all line requests seen", 64'(cq.size()), 64'h0);
        chk(tq.size() == 0, "R5", "all translations seen", 64'(tq.size()), 64'h0);
        if (hold) begin
            repeat (3) @(negedge clk);
            chk(!busy && !cache_req_valid && !tlb_req_valid, "R2", "held input not taken",
                64'(busy), 64'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !tlb_req_valid && !cache_req_valid && !done_valid, "R1", "reset idle",
            64'({busy, tlb_req_valid, cache_req_valid, done_valid}), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        // single-line loads, including exact line-end boundaries (R3)
        issue(32'h1234_5000, 2'd3, 1'b0, '0, 20'hABCDE, 20'h0, 1'b0, 1'b0);
        issue(32'h1234_503F, 2'd0, 1'b0, '0, 20'hABCDE, 20'h0, 1'b0, 1'b0);
        issue(32'h1234_5038, 2'd3, 1'b0, '0, 20'h0F0F0, 20'h0, 1'b0, 1'b0);
        issue(32'h1234_5A06, 2'd1, 1'b0, '0, 20'h00777, 20'h0, 1'b0, 1'b0);
        // in-page splits (R4)
        issue(32'h1234_517E, 2'd2, 1'b0, '0, 20'hABCDE, 20'h0, 1'b0, 1'b0);
        issue(32'h1234_503F, 2'd1, 1'b0, '0, 20'h13579, 20'h0, 1'b0, 1'b0);
        // page-crossing loads (R5)
        issue(32'h1234_5FFC, 2'd3, 1'b0, '0, 20'hABCDE, 20'h55501, 1'b0, 1'b0);
        issue(32'h0000_0FF9, 2'd3, 1'b0, '0, 20'h00042, 20'hFFFFF, 1'b0, 1'b0);
        // stores (R8)
        issue(32'h1234_507B, 2'd3, 1'b1, 64'h8877_6655_4433_2211, 20'h2468A, 20'h0, 1'b0, 1'b0);
        issue(32'h1234_5FFE, 2'd2, 1'b1, 64'h0000_0000_DDCC_BBAA, 20'hABCDE, 20'h31415, 1'b0, 1'b0);
        issue(32'h1234_5011, 2'd0, 1'b1, 64'h0000_0000_0000_005A, 20'hABCDE, 20'h0, 1'b0, 1'b0);
        issue(32'h1234_503E, 2'd1, 1'b1, 64'h0000_0000_0000_C3D4, 20'h11111, 20'h0, 1'b0, 1'b0);
        // second-page faults abort the whole access (R6)
        issue(32'h1234_5FFA, 2'd3, 1'b0, '0, 20'hABCDE, 20'h0, 1'b1, 1'b0);
        issue(32'h1234_5FFF, 2'd1, 1'b1, 64'h0000_0000_0000_BEEF, 20'hABCDE, 20'h0, 1'b1, 1'b0);
        // inputs held active while busy (R2)
        issue(32'h1234_5804, 2'd2, 1'b0, '0, 20'h0C0DE, 20'h0, 1'b0, 1'b1);
        issue(32'h1234_5FFD, 2'd2, 1'b0, '0, 20'h0C0DE, 20'h0ABBA, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk(dq.size() == 0, "R9", "every access completed once", 64'(dq.size()), 64'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > WDOG);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, WDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule